// File: doc/BRIEF.md
# One-Shot ADC Conversion Sequencer

This block runs single conversions on behalf of a host that reaches it through a small byte-wide register bus. The host first picks a channel and arms the converter. A start request then begins the conversion. The sequencer waits through a settling interval, which can be short or extended. It then holds a request to an external converter core until that core reports completion. The 12-bit sample is captured into a low/high register pair, and an end-of-conversion flag is raised. That flag drives an interrupt line unless a mask bit blocks it.

The block also holds two 2-bit current-source codes that it passes straight to the analog side. The first code selects 0, 5, 15 or 20 µA for codes 0 to 3. The second code selects 0, 10, 400 or 800 µA for codes 0 to 3. A force-on bit keeps the converter powered outside of conversions. A conversion that never completes is cut off by a watchdog, which records an error flag. Clearing the enable bit in the select register at any point returns the block to idle.

Register map (byte addresses on `wrAddr`/`rdAddr`):
- 0 select: channel in bits [3:0], enable in bit 4, start in bit 5.
- 1 control: code A in [1:0], code B in [3:2], force-on in bit 4, extended settle in bit 5, interrupt mask in bit 6, bit 7 spare.
- 2 result low byte.
- 3 result high nibble.
- 4 status: busy in bit 0, timeout error in bit 1, conversion-done in bit 2.

Top module: `oneshot_adc_seq`

## Requirements
- R1: After reset every readable register (addresses 0 to 4) reads 0, and `adcReq`, `eocIrq` and `adcPowerOn` are low.
- R2: A write to address 0 begins a conversion only when the block is idle and the written byte has both bit 4 (enable) and bit 5 (start) set. Bit 5 always reads back as 0. A start written with bit 4 clear begins nothing.
- R3: After an accepted start the block waits SETTLE_SHORT cycles, or SETTLE_LONG cycles when control bit 5 is set. It then raises `adcReq`, with `adcChan` equal to the channel field, and holds `adcChan` steady while `adcReq` is high.
- R4: When `adcDone` is high while `adcReq` is high, `adcData` is captured. Address 2 then reads bits [7:0], and address 3 reads bits [11:8] in its low nibble with the upper nibble 0. `adcReq` is low from the next cycle.
- R5: A capture sets status bit 2. `eocIrq` equals status bit 2 AND NOT control bit 6. Writing a 1 to status bit 2 clears it.
- R6: If `adcReq` has stayed high for TIMEOUT cycles without `adcDone`, the conversion is dropped. Status bit 1 is then set, and neither the result nor status bit 2 changes. Writing a 1 to status bit 1 clears it.
- R7: A write to address 0 with bit 4 clear, during settling or during the request, returns the block to idle with no capture. This holds even if `adcDone` arrives in the same cycle.
- R8: While busy, a write to address 0 with bit 4 set is ignored entirely. The select register keeps its value and no second conversion follows.
- R9: `adcDone` while `adcReq` is low changes neither the result nor any status bit.
- R10: `srcCodeA` and `srcCodeB` follow control bits [1:0] and [3:2]. `adcPowerOn` is high whenever control bit 4 is set or the block is busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Write address |
| wrData | input | 8 | Write data |
| rdAddr | input | 3 | Read address |
| rdData | output | 8 | Read data (combinational) |
| adcReq | output | 1 | Conversion request to the converter core |
| adcChan | output | 4 | Channel for the converter core |
| adcDone | input | 1 | Completion pulse from the converter core |
| adcData | input | 12 | Sample from the converter core |
| adcPowerOn | output | 1 | Keeps the converter state machine powered |
| srcCodeA | output | 2 | First current-source code |
| srcCodeB | output | 2 | Second current-source code |
| eocIrq | output | 1 | End-of-conversion interrupt |

## Verification
Some properties can be checked on every cycle, and the assertions cover those:
- `adcReq` never appears without converter power.
- A completion ends the request on the next cycle.
- The channel holds steady while a request is open.
- The request never outlasts the watchdog window.
- The interrupt only rises after a completion or a register write.

Other behaviours need the bench's scenarios, because they depend on register contents and exact cycle counts:
- The settle lengths in both modes.
- How the result is split across the two bytes.
- Masking of the interrupt.
- Rejection of starts while busy or without enable.
- The abort winning over a simultaneous completion.
- Stray completions being ignored.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] ADDR_SEL  = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_CTRL = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_RESL = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_RESH = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_STAT = 3'd4;

  // control register field positions
  localparam int CTL_FORCE = 4;
  localparam int CTL_EXT   = 5;
  localparam int CTL_MASK  = 6;

  // status register field positions
  localparam int ST_BUSY = 0;
  localparam int ST_ERR  = 1;
  localparam int ST_EOC  = 2;

  // datapath -> control: decoded host intent
  typedef struct packed {
    logic startReq;
    logic abortReq;
    logic extDelay;
  } hostReq_t;

  // control -> datapath: sequencing strobes
  typedef struct packed {
    logic busy;
    logic latchRes;
    logic setTimeout;
  } seqStrobe_t;
endpackage

// File: rtl/adc_seq_datapath.sv
module adc_seq_datapath
  import adc_seq_pkg::*;
#(
  parameter int CHAN_W = 4,
  parameter int RES_W  = 12
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [ADDR_W-1:0]   wrAddr,
  input  logic [DATA_W-1:0]   wrData,
  input  logic [ADDR_W-1:0]   rdAddr,
  output logic [DATA_W-1:0]   rdData,
  input  logic [RES_W-1:0]    adcData,
  input  seqStrobe_t          strobe,
  output hostReq_t            hostReq,
  output logic [CHAN_W-1:0]   adcChan,
  output logic                adcPowerOn,
  output logic [1:0]          srcCodeA,
  output logic [1:0]          srcCodeB,
  output logic                eocIrq
);
  localparam int EN_BIT    = CHAN_W;
  localparam int START_BIT = CHAN_W + 1;
  localparam int HI_W      = RES_W - DATA_W;

  logic [CHAN_W-1:0] selChan;
  logic              selEn;
  logic [DATA_W-1:0] ctrlReg;
  logic [RES_W-1:0]  resReg;
  logic              eocPend;
  logic              errFlag;

  logic selWr, ctrlWr, statWr;

  assign selWr  = wrEn && (wrAddr == ADDR_SEL);
  assign ctrlWr = wrEn && (wrAddr == ADDR_CTRL);
  assign statWr = wrEn && (wrAddr == ADDR_STAT);

  assign hostReq.startReq = selWr && !strobe.busy && wrData[EN_BIT] && wrData[START_BIT];
  assign hostReq.abortReq = selWr && !wrData[EN_BIT];
  assign hostReq.extDelay = ctrlReg[CTL_EXT];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      selChan <= '0;
      selEn   <= 1'b0;
    end else if (selWr && !(strobe.busy && wrData[EN_BIT])) begin
      selChan <= wrData[CHAN_W-1:0];
      selEn   <= wrData[EN_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)       ctrlReg <= '0;
    else if (ctrlWr) ctrlReg <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                resReg <= '0;
    else if (strobe.latchRes) resReg <= adcData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      eocPend <= 1'b0;
      errFlag <= 1'b0;
    end else begin
      if (strobe.latchRes)              eocPend <= 1'b1;
      else if (statWr && wrData[ST_EOC]) eocPend <= 1'b0;
      if (strobe.setTimeout)            errFlag <= 1'b1;
      else if (statWr && wrData[ST_ERR]) errFlag <= 1'b0;
    end
  end

  always_comb begin
    rdData = '0;
    case (rdAddr)
      ADDR_SEL:  rdData = DATA_W'({selEn, selChan});
      ADDR_CTRL: rdData = ctrlReg;
      ADDR_RESL: rdData = resReg[DATA_W-1:0];
      ADDR_RESH: rdData = DATA_W'(resReg[DATA_W +: HI_W]);
      ADDR_STAT: rdData = DATA_W'({eocPend, errFlag, strobe.busy});
      default:   rdData = '0;
    endcase
  end

  assign adcChan    = selChan;
  assign srcCodeA   = ctrlReg[1:0];
  assign srcCodeB   = ctrlReg[3:2];
  assign adcPowerOn = ctrlReg[CTL_FORCE] || strobe.busy;
  assign eocIrq     = eocPend && !ctrlReg[CTL_MASK];
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int SETTLE_SHORT = 4,
  parameter int SETTLE_LONG  = 16,
  parameter int TIMEOUT      = 64
) (
  input  logic       clk,
  input  logic       rstN,
  input  hostReq_t   hostReq,
  input  logic       adcDone,
  output logic       adcReq,
  output seqStrobe_t strobe
);
  localparam int MAX_CNT = (SETTLE_LONG > TIMEOUT) ? SETTLE_LONG : TIMEOUT;
  localparam int CNT_W   = $clog2(MAX_CNT + 1);
  localparam logic [CNT_W-1:0] SHORT_LOAD = CNT_W'(SETTLE_SHORT - 1);
  localparam logic [CNT_W-1:0] LONG_LOAD  = CNT_W'(SETTLE_LONG - 1);
  localparam logic [CNT_W-1:0] WD_LAST    = CNT_W'(TIMEOUT - 1);

  typedef enum logic [1:0] {S_IDLE, S_SETTLE, S_CONV} seqState_t;

  seqState_t        state;
  logic [CNT_W-1:0] cnt;
  logic             wdExpire;

  assign wdExpire = (state == S_CONV) && !adcDone && !hostReq.abortReq && (cnt == WD_LAST);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      cnt   <= '0;
    end else begin
      case (state)
        S_IDLE: begin
          if (hostReq.startReq) begin
            state <= S_SETTLE;
            cnt   <= hostReq.extDelay ? LONG_LOAD : SHORT_LOAD;
          end
        end
        S_SETTLE: begin
          if (hostReq.abortReq) begin
            state <= S_IDLE;
          end else if (cnt == '0) begin
            state <= S_CONV;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        S_CONV: begin
          if (hostReq.abortReq || adcDone || wdExpire) begin
            state <= S_IDLE;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign adcReq            = (state == S_CONV);
  assign strobe.busy       = (state != S_IDLE);
  assign strobe.latchRes   = (state == S_CONV) && adcDone && !hostReq.abortReq;
  assign strobe.setTimeout = wdExpire;
endmodule

// File: rtl/oneshot_adc_seq.sv
module oneshot_adc_seq
  import adc_seq_pkg::*;
#(
  parameter int CHAN_W       = 4,
  parameter int RES_W        = 12,
  parameter int SETTLE_SHORT = 4,
  parameter int SETTLE_LONG  = 16,
  parameter int TIMEOUT      = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [2:0]        wrAddr,
  input  logic [7:0]        wrData,
  input  logic [2:0]        rdAddr,
  output logic [7:0]        rdData,
  output logic              adcReq,
  output logic [CHAN_W-1:0] adcChan,
  input  logic              adcDone,
  input  logic [RES_W-1:0]  adcData,
  output logic              adcPowerOn,
  output logic [1:0]        srcCodeA,
  output logic [1:0]        srcCodeB,
  output logic              eocIrq
);
  hostReq_t   hostReq;
  seqStrobe_t strobe;

  adc_seq_datapath #(.CHAN_W(CHAN_W), .RES_W(RES_W)) u_dp (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .adcData(adcData), .strobe(strobe),
    .hostReq(hostReq), .adcChan(adcChan), .adcPowerOn(adcPowerOn),
    .srcCodeA(srcCodeA), .srcCodeB(srcCodeB), .eocIrq(eocIrq)
  );

  adc_seq_ctrl #(.SETTLE_SHORT(SETTLE_SHORT), .SETTLE_LONG(SETTLE_LONG),
                 .TIMEOUT(TIMEOUT)) u_ctrl (
    .clk(clk), .rstN(rstN), .hostReq(hostReq), .adcDone(adcDone),
    .adcReq(adcReq), .strobe(strobe)
  );
endmodule

// File: rtl/adc_seq_checker.sv
module adc_seq_checker #(
  parameter int CHAN_W  = 4,
  parameter int TIMEOUT = 64
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic              adcReq,
  input logic              adcDone,
  input logic [CHAN_W-1:0] adcChan,
  input logic              adcPowerOn,
  input logic              eocIrq
);
  localparam int RUN_W = $clog2(TIMEOUT + 1) + 1;
  logic [RUN_W-1:0] reqRun;

  always_ff @(posedge clk) begin
    if (!rstN)       reqRun <= '0;
    else if (adcReq) reqRun <= reqRun + 1'b1;
    else             reqRun <= '0;
  end

  a_r10_req_powered: assert property (@(posedge clk) disable iff (!rstN)
    adcReq |-> adcPowerOn);

  a_r4_done_ends_req: assert property (@(posedge clk) disable iff (!rstN)
    (adcReq && adcDone) |=> !adcReq);

  a_r3_chan_steady: assert property (@(posedge clk) disable iff (!rstN)
    adcReq |=> (!adcReq || $stable(adcChan)));

  a_r6_wd_bound: assert property (@(posedge clk) disable iff (!rstN)
    adcReq |-> (reqRun < RUN_W'(TIMEOUT)));

  a_r5_irq_cause: assert property (@(posedge clk) disable iff (!rstN)
    $rose(eocIrq) |-> ($past(adcDone) || $past(wrEn)));
endmodule

bind oneshot_adc_seq adc_seq_checker #(.CHAN_W(CHAN_W), .TIMEOUT(TIMEOUT)) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .adcReq(adcReq), .adcDone(adcDone),
  .adcChan(adcChan), .adcPowerOn(adcPowerOn), .eocIrq(eocIrq)
);

// File: tb/oneshot_adc_seq_tb.sv
module oneshot_adc_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int SHORT = 4;
  localparam int LONG  = 16;
  localparam int TMO   = 40;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  wrAddr = '0;
  logic [7:0]  wrData = '0;
  logic [2:0]  rdAddr = '0;
  logic [7:0]  rdData;
  logic        adcReq;
  logic [3:0]  adcChan;
  logic        adcDone = 1'b0;
  logic [11:0] adcData = '0;
  logic        adcPowerOn;
  logic [1:0]  srcCodeA, srcCodeB;
  logic        eocIrq;

  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  oneshot_adc_seq #(.SETTLE_SHORT(SHORT), .SETTLE_LONG(LONG), .TIMEOUT(TMO)) u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .adcReq(adcReq), .adcChan(adcChan),
    .adcDone(adcDone), .adcData(adcData), .adcPowerOn(adcPowerOn),
    .srcCodeA(srcCodeA), .srcCodeB(srcCodeB), .eocIrq(eocIrq)
  );

  typedef struct { logic [3:0] chan; logic [11:0] data; } item_t;
  item_t scoreQ[$];
  bit    modelOn = 1'b1;
  int    modelLat = 0;
  bit    pending = 1'b0;
  int    waitLeft = 0;
  logic [11:0] curData = '0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // converter model and scoreboard monitor
  always @(negedge clk) begin
    if (modelOn) begin
      if (adcDone) begin
        adcDone = 1'b0;
        pending = 1'b0;
      end else if (adcReq) begin
        if (!pending) begin
          pending = 1'b1;
          waitLeft = modelLat;
          if (scoreQ.size() == 0) begin
            check("R8 unexpected request", 1, 0);
            curData = '0;
          end else begin
            item_t it;
            it = scoreQ.pop_front();
            check("R3 channel at request", adcChan, it.chan);
            curData = it.data;
          end
        end
        if (waitLeft == 0) begin
          adcDone = 1'b1;
          adcData = curData;
        end else begin
          waitLeft--;
        end
      end else begin
        pending = 1'b0;
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    rdAddr = a;
    #1;
    d = rdData;
  endtask

  task automatic waitIdle();
    logic [7:0] s;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      rd(3'd4, s);
      if (!s[0]) break;
    end
  endtask

  task automatic waitReq();
    for (int i = 0; i < 3000; i++) begin
      if (adcReq) break;
      @(negedge clk);
    end
  endtask

  task automatic startConv(input logic [3:0] ch, input logic [11:0] d);
    item_t it;
    it.chan = ch; it.data = d;
    scoreQ.push_back(it);
    wr(3'd0, {2'b11, 2'b00, ch} & 8'h3F | 8'h30);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    checks++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int n;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), v);
      check("R1 register reset", v, 0);
    end
    check("R1 adcReq reset", adcReq, 0);
    check("R1 eocIrq reset", eocIrq, 0);
    check("R1 power reset", adcPowerOn, 0);

    // R10 control outputs
    wr(3'd1, 8'h1B);
    check("R10 srcCodeA", srcCodeA, 3);
    check("R10 srcCodeB", srcCodeB, 2);
    check("R10 force power", adcPowerOn, 1);
    rd(3'd1, v);
    check("R10 control readback", v, 8'h1B);
    wr(3'd1, 8'h00);
    check("R10 power off idle", adcPowerOn, 0);

    // R3 short settle, R2 start self-clear, R4 capture, R5 irq
    modelLat = 2;
    startConv(4'd5, 12'hA5C);
    rd(3'd0, v);
    check("R2 start bit reads 0", v, 8'h15);
    n = 0;
    while (!adcReq && n < 100) begin @(negedge clk); n++; end
    check("R3 short settle cycles", n, SHORT);
    check("R10 power while busy", adcPowerOn, 1);
    waitIdle();
    rd(3'd2, v); check("R4 result low byte", v, 8'h5C);
    rd(3'd3, v); check("R4 result high byte", v, 8'h0A);
    check("R5 irq raised", eocIrq, 1);
    rd(3'd4, v); check("R5 status done", v, 8'h04);
    wr(3'd4, 8'h04);
    check("R5 irq cleared", eocIrq, 0);

    // R3 long settle, full-scale value
    wr(3'd1, 8'h20);
    modelLat = 0;
    startConv(4'd9, 12'hFFF);
    n = 0;
    while (!adcReq && n < 100) begin @(negedge clk); n++; end
    check("R3 long settle cycles", n, LONG);
    waitIdle();
    rd(3'd2, v); check("R4 full-scale low", v, 8'hFF);
    rd(3'd3, v); check("R4 full-scale high masked", v, 8'h0F);
    wr(3'd4, 8'h04);

    // R5 mask
    wr(3'd1, 8'h40);
    startConv(4'd0, 12'h001);
    waitIdle();
    @(negedge clk);
    check("R5 masked irq low", eocIrq, 0);
    rd(3'd4, v); check("R5 masked status done", v, 8'h04);
    wr(3'd1, 8'h00);
    check("R5 unmask irq high", eocIrq, 1);
    wr(3'd4, 8'h04);

    // R8 writes while busy ignored
    modelLat = 20;
    startConv(4'd3, 12'h123);
    waitReq();
    wr(3'd0, 8'h3C);
    rd(3'd0, v); check("R8 select unchanged", v, 8'h13);
    check("R8 channel unchanged", adcChan, 3);
    waitIdle();
    rd(3'd2, v); check("R8 first result kept", v, 8'h23);
    n = 0;
    for (int i = 0; i < 30; i++) begin @(negedge clk); if (adcReq) n++; end
    check("R8 no second conversion", n, 0);
    wr(3'd4, 8'h04);

    // R2 start without enable
    wr(3'd0, 8'h27);
    n = 0;
    for (int i = 0; i < 30; i++) begin @(negedge clk); if (adcReq) n++; end
    check("R2 start without enable ignored", n, 0);
    rd(3'd0, v); check("R2 select readback", v, 8'h07);

    // R6 watchdog
    modelLat = 100000;
    startConv(4'd2, 12'h000);
    waitReq();
    n = 0;
    while (adcReq && n < 1000) begin @(negedge clk); n++; end
    check("R6 request length", n, TMO);
    rd(3'd4, v); check("R6 error flag only", v, 8'h02);
    check("R6 irq stays low", eocIrq, 0);
    rd(3'd2, v); check("R6 result unchanged", v, 8'h23);
    wr(3'd4, 8'h02);
    rd(3'd4, v); check("R6 error cleared", v, 8'h00);

    // R7 abort beats simultaneous done
    modelOn = 1'b0;
    wr(3'd0, 8'h31);
    waitReq();
    adcDone = 1'b1; adcData = 12'hABC;
    wrEn = 1'b1; wrAddr = 3'd0; wrData = 8'h00;
    @(negedge clk);
    wrEn = 1'b0; adcDone = 1'b0;
    check("R7 request dropped", adcReq, 0);
    rd(3'd4, v); check("R7 idle no flags", v, 8'h00);
    rd(3'd2, v); check("R7 no capture", v, 8'h23);
    check("R7 irq low", eocIrq, 0);

    // R7 abort during settle
    wr(3'd1, 8'h20);
    wr(3'd0, 8'h31);
    wr(3'd0, 8'h00);
    rd(3'd4, v); check("R7 settle abort idle", v, 8'h00);
    n = 0;
    for (int i = 0; i < 30; i++) begin @(negedge clk); if (adcReq) n++; end
    check("R7 no request after abort", n, 0);

    // R9 stray done while idle
    @(negedge clk);
    adcDone = 1'b1; adcData = 12'h777;
    @(negedge clk);
    adcDone = 1'b0;
    rd(3'd2, v); check("R9 result unchanged", v, 8'h23);
    rd(3'd4, v); check("R9 status unchanged", v, 8'h00);
    check("R9 irq low", eocIrq, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule